// File: doc/BRIEF.md
# DRAM Compressed Test Mode Controller

This block models the command decoding, mode control and data compression of a four-bit-wide asynchronous DRAM whose active-low row strobe, column strobe, write enable and output enable are sampled on a system clock. Each strobe is compared with its value at the previous edge. From the falling row strobe the block tells a row access from a refresh. When the column strobe is already low at that point, the cycle is a column-before-row refresh. When write enable is also low, it is the variant that enters test mode. A row cycle in which the column strobe never falls is a row-only refresh.

In normal mode each read or write touches the single cell chosen by the row and column address. In compressed test mode the two lowest column bits are ignored. A write copies each data bit into the four cells of its column group. A read returns, for each data bit, a flag that is high when those four cells agree and low when they differ. Either of the two plain refresh types leaves test mode. Read cycles and further test-entry cycles keep it.

Top module: `dram_ptm_ctrl`

## Requirements
- R1: After reset `test_mode` is 0 and `rdata_vld` is 0.
- R2: When `ras_n` is seen falling while `cas_n` and `we_n` are both low, `test_mode` is 1 from the next edge on. This also holds if it was already 1.
- R3: In normal mode a write stores `wdata` at cell address {row, col}. A read returns that cell on `rdata` from the edge that first sees `cas_n` low in the row cycle.
- R4: In test mode a write stores `wdata[b]` into all four cells of I/O b whose address equals {row, col} with col bits 1:0 replaced by 0, 1, 2 and 3. The col bits 1:0 supplied with the write are ignored.
- R5: In test mode a read sets `rdata[b]` to 1 when the four cells of I/O b in the addressed group (col bits 1:0 ignored) are all 0 or all 1, and to 0 otherwise.
- R6: When `ras_n` is seen falling while `cas_n` is low and `we_n` is high, `test_mode` is 0 from the next edge on, and an internal refresh row counter advances by one.
- R7: When a row cycle ends (`ras_n` seen rising) and `cas_n` was never seen falling during it, `test_mode` is 0 from the next edge on.
- R8: `rdata_vld` is high only during the read phase of a row cycle, and only while `oe_n` is low and `we_n` is high. The read phase runs from the edge that sees `cas_n` fall with `we_n` high until the edge that sees `cas_n` or `ras_n` rise. If `we_n` falls while `cas_n` stays low during a read phase, the cycle becomes a delayed write: `wdata` is stored at the latched column and `rdata_vld` drops.
- R9: A read cycle performed in test mode leaves `test_mode` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_addr | input | ROW_W | Row address, latched when the row strobe falls |
| col_addr | input | COL_W | Column address, latched when the column strobe falls |
| wdata | input | 4 | Write data, one bit per I/O |
| rdata | output | 4 | Read data, or per-I/O pass flags in test mode |
| rdata_vld | output | 1 | Read data valid; low means outputs released |
| test_mode | output | 1 | Compressed test mode active |

## Verification
Each strobe change is applied on a falling clock edge and detected at the next rising edge. Mode changes, stored writes and read data are all visible from that rising edge, so every result is due one rising edge after the stimulus. The bench samples each result at the falling edge that follows, half a period after it settles and before the next stimulus is applied. `rdata_vld` also depends on `oe_n` and `we_n` directly, and those checks are sampled in the same way.

// File: rtl/dram_ptm_pkg.sv
package dram_ptm_pkg;
   localparam int NIO = 4;   // data bits per access
   localparam int GRP = 4;   // cells merged per I/O in test mode

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_CBR   = 2'd1,   // column-before-row refresh, write high
      EV_WCBR  = 2'd2,   // column-before-row with write low: test entry
      EV_RONLY = 2'd3    // row cycle that never saw a column strobe
   } mode_ev_e;
endpackage

// File: rtl/dram_ptm_strobe.sv
module dram_ptm_strobe
   import dram_ptm_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [ROW_W-1:0] row_addr,
   input  logic [COL_W-1:0] col_addr,
   output mode_ev_e         ev,
   output logic             wr_en,
   output logic             rd_en,
   output logic             rd_act,
   output logic [ROW_W-1:0] acc_row,
   output logic [COL_W-1:0] acc_col
);
   logic ras_q, cas_q, we_q;
   logic row_act, cas_seen;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, acc_cas, late_wr;

   assign ras_fall = ras_q & ~ras_n;
   assign ras_rise = ~ras_q & ras_n;
   assign cas_fall = cas_q & ~cas_n;
   assign cas_rise = ~cas_q & cas_n;
   assign we_fall  = we_q & ~we_n;
   assign acc_cas  = row_act & ~ras_n & cas_fall;
   assign late_wr  = rd_act & we_fall & ~cas_n;

   always_comb begin
      ev = EV_NONE;
      if (ras_fall && !cas_n)
         ev = we_n ? EV_CBR : EV_WCBR;
      else if (ras_rise && row_act && !cas_seen)
         ev = EV_RONLY;
   end

   assign wr_en   = (acc_cas & ~we_n) | late_wr;
   assign rd_en   = acc_cas & we_n;
   assign acc_row = row_q;
   assign acc_col = acc_cas ? col_addr : col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q    <= 1'b1;
         cas_q    <= 1'b1;
         we_q     <= 1'b1;
         row_act  <= 1'b0;
         cas_seen <= 1'b0;
         rd_act   <= 1'b0;
         row_q    <= '0;
         col_q    <= '0;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         we_q  <= we_n;
         if (ras_fall && cas_n) begin
            row_act  <= 1'b1;
            cas_seen <= 1'b0;
            row_q    <= row_addr;
         end
         if (ras_rise) begin
            row_act <= 1'b0;
            rd_act  <= 1'b0;
         end else if (acc_cas) begin
            cas_seen <= 1'b1;
            col_q    <= col_addr;
            rd_act   <= we_n;
         end else if (cas_rise || late_wr) begin
            rd_act <= 1'b0;
         end
      end
   end

   // R8
   rd_phase_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |-> $past(!cas_n));

   // R8
   rd_wr_excl_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !wr_en);
endmodule

// File: rtl/dram_ptm_mode.sv
module dram_ptm_mode
   import dram_ptm_pkg::*;
#(
   parameter int ROW_W = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  mode_ev_e ev,
   output logic     test_mode
);
   logic [ROW_W-1:0] rcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_mode <= 1'b0;
         rcnt      <= '0;
      end else begin
         unique case (ev)
            EV_CBR: begin
               test_mode <= 1'b0;
               rcnt      <= rcnt + ROW_W'(1);
            end
            EV_WCBR: begin
               test_mode <= 1'b1;
               rcnt      <= rcnt + ROW_W'(1);
            end
            EV_RONLY: test_mode <= 1'b0;
            default: ;
         endcase
      end
   end

   // R2
   test_entry_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_WCBR) |=> test_mode);

   // R6
   cbr_exit_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_CBR) |=> !test_mode);

   // R6
   rcnt_step_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_CBR) |=> (rcnt == $past(rcnt) + ROW_W'(1)));

   // R7
   ronly_exit_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_RONLY) |=> !test_mode);
endmodule

// File: rtl/dram_ptm_array.sv
module dram_ptm_array
   import dram_ptm_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_mode,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [ROW_W-1:0] acc_row,
   input  logic [COL_W-1:0] acc_col,
   input  logic [NIO-1:0]   wdata,
   output logic [NIO-1:0]   rdata_q
);
   localparam int AW    = ROW_W + COL_W;
   localparam int DEPTH = 1 << AW;

   if (COL_W < 2) begin : g_badcol
      $error("dram_ptm_array: COL_W must be at least 2");
   end
   if (ROW_W < 1) begin : g_badrow
      $error("dram_ptm_array: ROW_W must be at least 1");
   end

   logic [AW-1:0] addr, base;
   assign addr = {acc_row, acc_col};
   assign base = addr & ~AW'(GRP - 1);

   for (genvar b = 0; b < NIO; b++) begin : g_io
      logic [DEPTH-1:0] cells;
      logic [GRP-1:0]   grp;
      logic             rd_bit;

      assign grp    = cells[base +: GRP];
      assign rd_bit = test_mode ? ((&grp) | ~(|grp)) : cells[addr];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells      <= '0;
            rdata_q[b] <= 1'b0;
         end else begin
            if (wr_en) begin
               if (test_mode) begin
                  for (int k = 0; k < GRP; k++)
                     cells[base + AW'(k)] <= wdata[b];
               end else begin
                  cells[addr] <= wdata[b];
               end
            end
            if (rd_en)
               rdata_q[b] <= rd_bit;
         end
      end
   end
endmodule

// File: rtl/dram_ptm_ctrl.sv
module dram_ptm_ctrl
   import dram_ptm_pkg::*;
#(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [ROW_W-1:0] row_addr,
   input  logic [COL_W-1:0] col_addr,
   input  logic [3:0]       wdata,
   output logic [3:0]       rdata,
   output logic             rdata_vld,
   output logic             test_mode
);
   mode_ev_e         ev;
   logic             wr_en, rd_en, rd_act;
   logic [ROW_W-1:0] acc_row;
   logic [COL_W-1:0] acc_col;

   dram_ptm_strobe #(.ROW_W(ROW_W), .COL_W(COL_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .row_addr(row_addr), .col_addr(col_addr), .ev(ev), .wr_en(wr_en),
      .rd_en(rd_en), .rd_act(rd_act), .acc_row(acc_row), .acc_col(acc_col)
   );

   dram_ptm_mode #(.ROW_W(ROW_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .ev(ev), .test_mode(test_mode)
   );

   dram_ptm_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .wr_en(wr_en),
      .rd_en(rd_en), .acc_row(acc_row), .acc_col(acc_col), .wdata(wdata),
      .rdata_q(rdata)
   );

   assign rdata_vld = rd_act & ~oe_n & we_n;

   // R8
   out_release_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !rdata_vld);
endmodule

// File: tb/dram_ptm_ctrl_tb.sv
`timescale 1ns/1ps
module dram_ptm_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ras_n, cas_n, we_n, oe_n;
   logic [2:0] row_addr, col_addr;
   logic [3:0] wdata;
   logic [3:0] rdata;
   logic       rdata_vld, test_mode;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   dram_ptm_ctrl #(.ROW_W(3), .COL_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .row_addr(row_addr), .col_addr(col_addr), .wdata(wdata),
      .rdata(rdata), .rdata_vld(rdata_vld), .test_mode(test_mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic do_write(input logic [2:0] r, input logic [2:0] c, input logic [3:0] d);
      ras_n = 1'b0; row_addr = r; tick();
      col_addr = c; wdata = d; we_n = 1'b0; cas_n = 1'b0; tick();
      cas_n = 1'b1; we_n = 1'b1; tick();
      ras_n = 1'b1; tick();
   endtask

   task automatic do_read(input logic [2:0] r, input logic [2:0] c,
                          output logic [3:0] d, output logic v);
      ras_n = 1'b0; row_addr = r; tick();
      col_addr = c; oe_n = 1'b0; cas_n = 1'b0; tick();
      d = rdata; v = rdata_vld;
      cas_n = 1'b1; tick();
      oe_n = 1'b1; ras_n = 1'b1; tick();
   endtask

   task automatic col_first(input logic we_low);
      cas_n = 1'b0; we_n = ~we_low; tick();
      ras_n = 1'b0; tick();
      cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; tick();
   endtask

   task automatic row_only(input logic [2:0] r);
      ras_n = 1'b0; row_addr = r; tick();
      tick();
      ras_n = 1'b1; tick();
   endtask

   task automatic t_reset();
      check("R1 test_mode", test_mode, 0);
      check("R1 rdata_vld", rdata_vld, 0);
   endtask

   task automatic t_normal();
      logic [3:0] d; logic v;
      do_write(3'd1, 3'd3, 4'hA);
      do_write(3'd1, 3'd2, 4'h5);
      do_read(3'd1, 3'd3, d, v);
      check("R3 read 1/3", d, 4'hA);
      check("R8 vld in read", v, 1);
      do_read(3'd1, 3'd2, d, v);
      check("R3 read 1/2", d, 4'h5);
      check("R8 vld after cycle", rdata_vld, 0);
   endtask

   task automatic t_test_write();
      logic [3:0] d; logic v;
      for (int c = 4; c < 8; c++) do_write(3'd2, 3'(c), 4'b0101);
      col_first(1'b1);
      check("R2 enter", test_mode, 1);
      do_write(3'd2, 3'd5, 4'b1010);
      col_first(1'b0);
      check("R6 cbr exit", test_mode, 0);
      for (int c = 4; c < 8; c++) begin
         do_read(3'd2, 3'(c), d, v);
         check("R4 fanout cell", d, 4'b1010);
      end
      do_read(3'd2, 3'd3, d, v);
      check("R4 neighbour group untouched", d, 4'h0);
   endtask

   task automatic t_test_pass();
      logic [3:0] d; logic v;
      col_first(1'b1);
      do_read(3'd2, 3'd6, d, v);
      check("R5 pass col6", d, 4'hF);
      check("R8 vld test read", v, 1);
      do_read(3'd2, 3'd4, d, v);
      check("R5 pass col4", d, 4'hF);
      check("R9 stays after read", test_mode, 1);
      col_first(1'b1);
      check("R2 repeat entry", test_mode, 1);
   endtask

   task automatic t_test_fail();
      logic [3:0] d; logic v;
      col_first(1'b0);
      do_write(3'd2, 3'd7, 4'b1011);
      col_first(1'b1);
      do_read(3'd2, 3'd5, d, v);
      check("R5 fail on io0", d, 4'b1110);
      row_only(3'd3);
      check("R7 ras-only exit", test_mode, 0);
   endtask

   task automatic t_outputs();
      logic [3:0] d; logic v;
      ras_n = 1'b0; row_addr = 3'd5; tick();
      col_addr = 3'd1; oe_n = 1'b1; cas_n = 1'b0; tick();
      check("R8 vld oe high", rdata_vld, 0);
      oe_n = 1'b0; tick();
      check("R8 vld oe low", rdata_vld, 1);
      wdata = 4'h6; we_n = 1'b0; tick();
      check("R8 vld delayed write", rdata_vld, 0);
      cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
      ras_n = 1'b1; tick();
      do_read(3'd5, 3'd1, d, v);
      check("R8 delayed write data", d, 4'h6);
   endtask

   initial begin
      for (int i = 0; i < 5000; i++) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      row_addr = '0; col_addr = '0; wdata = '0;
      tick(); tick();
      rst_n = 1'b1; tick();
      t_reset();
      t_normal();
      t_test_write();
      t_test_pass();
      t_test_fail();
      t_outputs();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule